// File: doc/BRIEF.md
# Debug Access Key Unlock

This block keeps the debug (emulation) features and the external boot sources of a secured device closed until a secret 64-bit key has been presented. The key arrives one bit per clock through a test-data serial path into a shift register. It is then compared with a device key, fixed at build time as a parameter, when an update strobe arrives. If the two are equal, a sticky unlock flag is set and both gated features open.

If the key does not match, nothing happens: there is no error state and no lockout, and the device simply stays as it was. While security is enabled and the flag is clear, the block holds the boot source selection at internal memory. When security is disabled, everything is open no matter what has been shifted in. The flag is cleared only by reset.

Top module: `dbg_key_gate`

## Requirements
- R1: After reset the device is locked: with `sec_en` high, `emu_enable` and `ext_boot_enable` are 0 and `force_internal_boot` is 1.
- R2: On every clock with `shift_en` high, `key_bit` enters the top of a 64-bit register and all other bits move one place toward bit 0. Bits are sent least significant first, so after 64 shifts the first bit sent lines up with bit 0 of the device key.
- R3: Shifting alone never unlocks. The comparison happens only on a clock where `update_stb` is high.
- R4: An update whose register contents equal the device key `DEV_KEY` unlocks the device. From the next cycle `emu_enable` and `ext_boot_enable` are 1 and `force_internal_boot` is 0.
- R5: An update whose register contents differ from `DEV_KEY` in any bit, including bit 0 or bit 63, leaves a locked device locked.
- R6: Once the device is unlocked, it stays unlocked through later wrong keys and updates until reset.
- R7: With `sec_en` low, `emu_enable` and `ext_boot_enable` are 1 and `force_internal_boot` is 0, whatever key has been shifted.
- R8: When `shift_en` and `update_stb` are high in the same cycle, the comparison uses the register contents from before that cycle's shift.
- R9: If more than 64 bits are shifted, only the last 64 are compared. Older bits fall off the bottom of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears the unlock flag and the shift register |
| sec_en | input | 1 | Security enable; when low, all gated features are open |
| key_bit | input | 1 | Serial key data, least significant bit first |
| shift_en | input | 1 | Shift `key_bit` into the key register this cycle |
| update_stb | input | 1 | Compare the key register with the device key this cycle |
| emu_enable | output | 1 | Debug and emulation features allowed |
| ext_boot_enable | output | 1 | External boot sources allowed |
| force_internal_boot | output | 1 | Boot must come from internal memory only |

## Verification
A shift and a compare can fall in the same clock. The bench provokes this in two ways. In the first, the whole correct key has been loaded and an extra shift coincides with the update. In the second, the final key bit arrives together with the update. The first case must unlock and the second must not, because the compare sees the register as it stood before that cycle's shift. In the second case, a later update with no shift must then unlock, which shows that the shift did complete.

// File: rtl/dbg_key_gate.sv
module dbg_key_gate #(
  parameter int KEY_W = 64,
  parameter logic [KEY_W-1:0] DEV_KEY = 64'hA5C3_1E7F_0D92_B468
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_en,
  input  logic key_bit,
  input  logic shift_en,
  input  logic update_stb,
  output logic emu_enable,
  output logic ext_boot_enable,
  output logic force_internal_boot
);

  logic [KEY_W-1:0] key_sr;
  logic             unlocked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        key_sr <= '0;
    else if (shift_en) key_sr <= {key_bit, key_sr[KEY_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              unlocked_q <= 1'b0;
    else if (update_stb && key_sr == DEV_KEY) unlocked_q <= 1'b1;
  end

  assign emu_enable          = unlocked_q | ~sec_en;
  assign ext_boot_enable     = unlocked_q | ~sec_en;
  assign force_internal_boot = sec_en & ~unlocked_q;

endmodule

// File: rtl/dbg_key_gate_chk.sv
module dbg_key_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic sec_en,
  input logic update_stb,
  input logic unlocked_q,
  input logic emu_enable,
  input logic ext_boot_enable,
  input logic force_internal_boot
);

  // R1
  locked_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_internal_boot |-> (!emu_enable && !ext_boot_enable));

  // R7
  open_when_unsecured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_en |-> (emu_enable && ext_boot_enable && !force_internal_boot));

  // R6
  unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked_q |=> unlocked_q);

  // R3
  unlock_needs_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update_stb |=> $stable(unlocked_q));

  // R4
  unlock_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked_q |-> (emu_enable && ext_boot_enable && !force_internal_boot));

endmodule

bind dbg_key_gate dbg_key_gate_chk chk_i (
  .clk                (clk),
  .rst_n              (rst_n),
  .sec_en             (sec_en),
  .update_stb         (update_stb),
  .unlocked_q         (unlocked_q),
  .emu_enable         (emu_enable),
  .ext_boot_enable    (ext_boot_enable),
  .force_internal_boot(force_internal_boot)
);

// File: tb/dbg_key_gate_tb_top.sv
module dbg_key_gate_tb_top;
  localparam logic [63:0] KEY = 64'h3C5A_9E01_77D4_B2E8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_en = 1'b1, key_bit = 1'b0, shift_en = 1'b0, update_stb = 1'b0;
  logic emu_enable, ext_boot_enable, force_internal_boot;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dbg_key_gate #(.KEY_W(64), .DEV_KEY(KEY)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .key_bit(key_bit),
    .shift_en(shift_en), .update_stb(update_stb), .emu_enable(emu_enable),
    .ext_boot_enable(ext_boot_enable), .force_internal_boot(force_internal_boot)
  );

  // {sec_en, key}
  localparam int NV = 7;
  localparam logic [64:0] VEC [NV] = '{
    {1'b1, KEY},
    {1'b1, 64'h0},
    {1'b1, KEY ^ 64'h1},
    {1'b1, KEY ^ 64'h8000_0000_0000_0000},
    {1'b1, ~64'h0},
    {1'b0, 64'h0},
    {1'b1, {KEY[31:0], KEY[63:32]}}
  };

  task automatic chk(string tag, logic open_exp);
    logic [2:0] act, exp;
    act = {emu_enable, ext_boot_enable, force_internal_boot};
    exp = {open_exp, open_exp, ~open_exp};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {emu,ext,force} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; shift_en = 1'b0; update_stb = 1'b0; key_bit = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic shift_bits(logic [63:0] k, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      shift_en = 1'b1; key_bit = k[i];
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic pulse_update();
    update_stb = 1'b1;
    @(negedge clk);
    update_stb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    sec_en = 1'b1;
    do_reset();
    chk("R1 reset locked", 1'b0);

    // R2 R4 R5 R7: table walk, each row from reset
    for (int v = 0; v < NV; v++) begin
      do_reset();
      sec_en = VEC[v][64];
      shift_bits(VEC[v][63:0], 64);
      pulse_update();
      chk(VEC[v][63:0] == KEY ? "R4 match unlock" :
          (!VEC[v][64] ? "R7 unsecured open" : "R5 mismatch ignored"),
          (VEC[v][63:0] == KEY) || !VEC[v][64]);
    end
    sec_en = 1'b1;

    // R3: shift without update stays locked
    do_reset();
    shift_bits(KEY, 64);
    repeat (3) @(negedge clk);
    chk("R3 no update no unlock", 1'b0);
    pulse_update();
    chk("R3 update then unlocks", 1'b1);

    // R6: wrong key after unlock does not relock
    shift_bits(~KEY, 64);
    pulse_update();
    chk("R6 sticky after wrong key", 1'b1);
    do_reset();
    chk("R6 reset clears unlock", 1'b0);

    // R7: no key, security off then on
    sec_en = 1'b0;
    @(negedge clk);
    chk("R7 unsecured without key", 1'b1);
    sec_en = 1'b1;
    @(negedge clk);
    chk("R7 secured again locked", 1'b0);

    // R8a: full key loaded, extra shift with update -> compare old contents
    do_reset();
    shift_bits(KEY, 64);
    shift_en = 1'b1; key_bit = 1'b1; update_stb = 1'b1;
    @(negedge clk);
    shift_en = 1'b0; update_stb = 1'b0;
    chk("R8 shift+update uses pre-shift match", 1'b1);

    // R8b: final bit with update -> compare incomplete contents
    do_reset();
    shift_bits(KEY, 63);
    shift_en = 1'b1; key_bit = KEY[63]; update_stb = 1'b1;
    @(negedge clk);
    shift_en = 1'b0; update_stb = 1'b0;
    chk("R8 last bit with update stays locked", 1'b0);
    pulse_update();
    chk("R8 later update after completed shift", 1'b1);

    // R9: leading garbage falls off
    do_reset();
    shift_bits(64'hFF, 8);
    shift_bits(KEY, 64);
    pulse_update();
    chk("R9 only last 64 bits count", 1'b1);

    // R2: bit order, key sent MSB first must not match
    do_reset();
    for (int i = 63; i >= 0; i--) begin
      @(negedge clk);
      shift_en = 1'b1; key_bit = KEY[i];
    end
    @(negedge clk);
    shift_en = 1'b0;
    pulse_update();
    chk("R2 reversed bit order rejected", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule